// File: doc/BRIEF.md
# I2C Multi-Address Match Unit

This block sits behind an I2C slave's bit and byte front end. When the front end has captured the first byte after a start condition, it presents that byte together with a one-cycle strobe. The unit compares the 7-bit address against every address the device answers to and, one clock later, reports whether to acknowledge and which class of address was hit. The candidates are the device's own address (a fixed upper prefix joined with pin-strapped low bits), a set of programmable group addresses that can each be switched on or off, one programmable broadcast address with its own enable, and a reserved reset address.

For the rest of the transaction the unit also decides the acknowledge of each data byte, and it clears its state on a stop. When the reserved reset address is hit with a write, the unit follows the two-byte key sequence that must come next. It raises a one-cycle reset request only when exactly the two expected key bytes have arrived, in order, before the stop. A wrong byte, an extra byte, a missing byte or a repeated start abandons the request.

Top module: `i2c_addr_match`

## Requirements
- R1: Bits 7:1 of `addr_byte_i` are the address and bit 0 selects the operation (1 = read, 0 = write). Every decision appears on `ack_o`/`class_o` on the clock edge after the strobe that captures it.
- R2: The address `{DEV_PREFIX, pin_addr_i}` is acknowledged for both reads and writes, with class code 1.
- R3: Group address k (k = 0..NUM_SUB-1) is acknowledged for reads and writes only while `sub_en_i[k]` is 1, with class code 2+k. Only bits 7:1 of its byte in `sub_addr_i` are compared, and bit 0 of that byte has no effect.
- R4: The broadcast address is acknowledged for reads and writes only while `allcall_en_i` is 1, with class code NUM_SUB+2 (5 by default). Only bits 7:1 of `allcall_addr_i` are compared.
- R5: When several enabled addresses match, a single acknowledge is given, and the class is chosen in the order device, then group 0, 1, 2, then broadcast.
- R6: The reserved address `SRST_ADDR` takes precedence over all other matches. With a write it is acknowledged with class code NUM_SUB+3 (6 by default). With a read it is not acknowledged and the class code is 0.
- R7: An address that matches nothing gets no acknowledge and class code 0, and the data bytes of that transaction are not acknowledged.
- R8: In a transaction with class codes 1 to NUM_SUB+2, every data byte is acknowledged.
- R9: After a reset-address write, a first data byte equal to `SRST_KEY0` and a second equal to `SRST_KEY1` are each acknowledged. A stop that follows them raises `srst_req_o` for exactly one cycle, on the edge that captures the stop.
- R10: In a reset transaction, a key byte with the wrong value and any byte after the second are not acknowledged, and the stop that ends such a transaction raises no reset request.
- R11: Out of reset, and after every stop, `ack_o`, `class_o` and `srst_req_o` are 0.
- R12: A new address strobe in the middle of a reset sequence abandons that sequence, and the new address is evaluated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_valid_i | input | 1 | One-cycle strobe: address byte after start captured |
| addr_byte_i | input | 8 | Address in bits 7:1, read/write in bit 0 |
| data_valid_i | input | 1 | One-cycle strobe: data byte captured |
| data_byte_i | input | 8 | Captured data byte |
| stop_i | input | 1 | One-cycle strobe: stop condition seen |
| pin_addr_i | input | PIN_W | Pin-strapped low bits of the device address |
| sub_en_i | input | NUM_SUB | Enable of each group address |
| sub_addr_i | input | NUM_SUB*8 | Group address registers, group k in byte k |
| allcall_en_i | input | 1 | Enable of the broadcast address |
| allcall_addr_i | input | 8 | Broadcast address register |
| ack_o | output | 1 | Acknowledge decision for the last captured byte |
| class_o | output | CLS_W | Class of the current transaction's address |
| srst_req_o | output | 1 | One-cycle software reset request |

## Verification
Random transactions steer the address toward each candidate in turn: the device address, each group address, the broadcast address, the reserved address and an arbitrary value. Enables, register low bits and read/write are drawn at random. This separates a wrong enable gate, a compare that includes bit 0 and a wrong class code from one another. Directed cases place several equal addresses in every priority order, which exposes a wrong priority. They also walk the reset-key path in its correct form and in each malformed form (wrong key, third byte, read, repeated start), so a reset that fires too readily or an acknowledge that outlives the second key is caught.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_KEY1,
    SQ_DONE,
    SQ_BAD
  } srst_state_e;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  logic              en_i,
  input  logic [ADDR_W-1:0] ref_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = en_i && (ref_i == addr_i);
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int N = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    any_o = |req_i;
  end

  always_comb begin
    assert_grant_onehot_R5: assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0)
                                    && ((gnt_o != '0) == any_o))
      else $error("grant not a single requested line");
  end
endmodule

// File: rtl/i2c_am_srst_seq.sv
module i2c_am_srst_seq
  import i2c_am_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY0 = 8'hA5,
  parameter logic [BYTE_W-1:0] KEY1 = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              start_i,
  input  logic              data_valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              stop_i,
  output logic              ack_o,
  output logic              req_o
);
  srst_state_e state_q;

  assign ack_o = (state_q == SQ_ARMED && data_i == KEY0) ||
                 (state_q == SQ_KEY1 && data_i == KEY1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      req_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (restart_i) begin
        state_q <= start_i ? SQ_ARMED : SQ_IDLE;
      end else if (stop_i) begin
        req_o   <= (state_q == SQ_DONE);
        state_q <= SQ_IDLE;
      end else if (data_valid_i) begin
        unique case (state_q)
          SQ_ARMED: state_q <= (data_i == KEY0) ? SQ_KEY1 : SQ_BAD;
          SQ_KEY1:  state_q <= (data_i == KEY1) ? SQ_DONE : SQ_BAD;
          SQ_DONE:  state_q <= SQ_BAD;
          default:  state_q <= state_q;
        endcase
      end
    end
  end

  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o) else $error("reset request longer than one cycle");

  assert_req_after_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(stop_i && !restart_i)) else $error("reset request without stop");

  assert_done_via_key1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_DONE && $past(state_q) != SQ_DONE) |->
      $past(state_q == SQ_KEY1 && data_valid_i && data_i == KEY1))
    else $error("sequence completed out of order");
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int                NUM_SUB    = 3,
  parameter int                PIN_W      = 4,
  parameter logic [ADDR_W-PIN_W-1:0] DEV_PREFIX = 3'b110,
  parameter logic [ADDR_W-1:0] SRST_ADDR  = 7'h6B,
  parameter logic [BYTE_W-1:0] SRST_KEY0  = 8'hA5,
  parameter logic [BYTE_W-1:0] SRST_KEY1  = 8'h5A,
  localparam int               CLS_W      = $clog2(NUM_SUB + 4)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      addr_valid_i,
  input  logic [BYTE_W-1:0]         addr_byte_i,
  input  logic                      data_valid_i,
  input  logic [BYTE_W-1:0]         data_byte_i,
  input  logic                      stop_i,
  input  logic [PIN_W-1:0]          pin_addr_i,
  input  logic [NUM_SUB-1:0]        sub_en_i,
  input  logic [NUM_SUB*BYTE_W-1:0] sub_addr_i,
  input  logic                      allcall_en_i,
  input  logic [BYTE_W-1:0]         allcall_addr_i,
  output logic                      ack_o,
  output logic [CLS_W-1:0]          class_o,
  output logic                      srst_req_o
);
  localparam int NCAND = NUM_SUB + 2;
  localparam int IDX_W = $clog2(NCAND);
  localparam logic [CLS_W-1:0] CLS_NONE = '0;
  localparam logic [CLS_W-1:0] CLS_SRST = CLS_W'(NUM_SUB + 3);

  logic [ADDR_W-1:0] addr7;
  logic              rw_rd;
  logic [NCAND-1:0]  hit;
  logic [NCAND-1:0]  gnt;
  logic [IDX_W-1:0]  win_idx;
  logic              any_hit;
  logic              srst_hit;
  logic [CLS_W-1:0]  cls_nxt;
  logic              seq_ack;
  logic              ack_q;
  logic [CLS_W-1:0]  cls_q;
  logic              unused_lsb;

  assign addr7 = addr_byte_i[BYTE_W-1:1];
  assign rw_rd = addr_byte_i[0];

  // candidate 0: device, 1..NUM_SUB: group, NCAND-1: broadcast
  i2c_am_cmp u_dev_cmp (
    .en_i  (1'b1),
    .ref_i ({DEV_PREFIX, pin_addr_i}),
    .addr_i(addr7),
    .hit_o (hit[0])
  );

  for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
    i2c_am_cmp u_sub_cmp (
      .en_i  (sub_en_i[k]),
      .ref_i (sub_addr_i[k*BYTE_W+1 +: ADDR_W]),
      .addr_i(addr7),
      .hit_o (hit[k+1])
    );
  end

  i2c_am_cmp u_all_cmp (
    .en_i  (allcall_en_i),
    .ref_i (allcall_addr_i[BYTE_W-1:1]),
    .addr_i(addr7),
    .hit_o (hit[NCAND-1])
  );

  i2c_am_prio #(.N(NCAND)) u_prio (
    .req_i(hit),
    .gnt_o(gnt),
    .idx_o(win_idx),
    .any_o(any_hit)
  );

  assign srst_hit = (addr7 == SRST_ADDR);

  always_comb begin
    if (srst_hit)     cls_nxt = rw_rd ? CLS_NONE : CLS_SRST;
    else if (any_hit) cls_nxt = CLS_W'(win_idx) + CLS_W'(1);
    else              cls_nxt = CLS_NONE;
  end

  i2c_am_srst_seq #(.KEY0(SRST_KEY0), .KEY1(SRST_KEY1)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (addr_valid_i),
    .start_i     (srst_hit && !rw_rd),
    .data_valid_i(data_valid_i),
    .data_i      (data_byte_i),
    .stop_i      (stop_i),
    .ack_o       (seq_ack),
    .req_o       (srst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      cls_q <= CLS_NONE;
    end else if (addr_valid_i) begin
      ack_q <= (cls_nxt != CLS_NONE);
      cls_q <= cls_nxt;
    end else if (stop_i) begin
      ack_q <= 1'b0;
      cls_q <= CLS_NONE;
    end else if (data_valid_i) begin
      ack_q <= (cls_q == CLS_SRST) ? seq_ack : (cls_q != CLS_NONE);
    end
  end

  assign ack_o   = ack_q;
  assign class_o = cls_q;

  always_comb begin
    unused_lsb = allcall_addr_i[0] ^ (|gnt);
    for (int k = 0; k < NUM_SUB; k++) unused_lsb = unused_lsb ^ sub_addr_i[k*BYTE_W];
  end

  assert_srst_read_nack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && addr_byte_i[BYTE_W-1:1] == SRST_ADDR && addr_byte_i[0])
      |=> (!ack_o && class_o == '0)) else $error("reset address read acknowledged");

  assert_stop_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !addr_valid_i) |=> (!ack_o && class_o == '0)) else $error("stop left state");

  assert_unmatched_data_nack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == '0 && data_valid_i && !addr_valid_i && !stop_i) |=> !ack_o)
    else $error("data acked without match");

  assert_ack_has_class_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> (class_o != '0)) else $error("ack without class");
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  localparam int NSUB = 3;
  localparam logic [6:0] SRST = 7'h6B;
  localparam logic [7:0] K0 = 8'hA5;
  localparam logic [7:0] K1 = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0, data_valid = 1'b0, stop = 1'b0;
  logic [7:0] addr_byte = '0, data_byte = '0;
  logic [3:0] pins = '0;
  logic [NSUB-1:0] sub_en = '0;
  logic [NSUB*8-1:0] sub_addr = {8'hD8, 8'hD4, 8'hD2};
  logic all_en = 1'b1;
  logic [7:0] all_addr = 8'hD0;
  logic ack;
  logic [2:0] cls;
  logic srst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_match dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_valid_i(addr_valid), .addr_byte_i(addr_byte),
    .data_valid_i(data_valid), .data_byte_i(data_byte),
    .stop_i(stop), .pin_addr_i(pins),
    .sub_en_i(sub_en), .sub_addr_i(sub_addr),
    .allcall_en_i(all_en), .allcall_addr_i(all_addr),
    .ack_o(ack), .class_o(cls), .srst_req_o(srst_req)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_class(logic [7:0] a);
    logic [6:0] a7 = a[7:1];
    if (a7 == SRST) return a[0] ? 0 : 6;
    if (a7 == {3'b110, pins}) return 1;
    for (int k = 0; k < NSUB; k++)
      if (sub_en[k] && sub_addr[k*8+1 +: 7] == a7) return 2 + k;
    if (all_en && all_addr[7:1] == a7) return 5;
    return 0;
  endfunction

  task automatic pulse_addr(logic [7:0] a);
    @(negedge clk); addr_byte = a; addr_valid = 1'b1;
    @(negedge clk); addr_valid = 1'b0;
  endtask

  task automatic pulse_data(logic [7:0] d);
    @(negedge clk); data_byte = d; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic pulse_stop(string req, int exp_req);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check({req, " stop clears ack"}, int'(ack), 0);
    check({req, " stop clears class"}, int'(cls), 0);
    check({req, " reset request at stop"}, int'(srst_req), exp_req);
    @(negedge clk);
    check({req, " reset request one cycle"}, int'(srst_req), 0);
  endtask

  task automatic addr_chk(string req, logic [7:0] a, int exp_c);
    pulse_addr(a);
    check({req, " class"}, int'(cls), exp_c);
    check({req, " ack"}, int'(ack), int'(exp_c != 0));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 reset ack", int'(ack), 0);
    check("R11 reset class", int'(cls), 0);
    check("R11 reset srst", int'(srst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // defaults: broadcast enabled, groups disabled
    addr_chk("R4 broadcast write", 8'hD0, 5);
    pulse_data(8'h33); check("R8 broadcast data ack", int'(ack), 1);
    pulse_stop("R11", 0);
    addr_chk("R4 broadcast read", 8'hD1, 5); pulse_stop("R11", 0);
    addr_chk("R3 group disabled", 8'hD2, 0);
    pulse_data(8'h11); check("R7 unmatched data nack", int'(ack), 0);
    pulse_stop("R11", 0);

    // device read/write, R1 bit 0 is operation
    pins = 4'h5;
    addr_chk("R2 R1 device write", 8'hCA, 1); pulse_stop("R11", 0);
    addr_chk("R2 R1 device read", 8'hCB, 1); pulse_stop("R11", 0);

    // group bit 0 ignored
    sub_en = 3'b010; sub_addr[15:8] = 8'h47;
    addr_chk("R3 group lsb ignored", 8'h46, 3); pulse_stop("R11", 0);
    addr_chk("R3 group read", 8'h47, 3); pulse_stop("R11", 0);
    all_en = 1'b0;
    addr_chk("R4 broadcast disabled", 8'hD0, 0); pulse_stop("R11", 0);

    // priority
    pins = 4'h0; all_en = 1'b1; sub_en = 3'b111;
    sub_addr = {8'hC0, 8'hC0, 8'hC0}; all_addr = 8'hC0;
    addr_chk("R5 device first", 8'hC0, 1); pulse_stop("R11", 0);
    pins = 4'h9;
    addr_chk("R5 group0 before others", 8'hC0, 2); pulse_stop("R11", 0);
    sub_en = 3'b110;
    addr_chk("R5 group1 next", 8'hC0, 3); pulse_stop("R11", 0);
    sub_en = 3'b100;
    addr_chk("R5 group2 before broadcast", 8'hC0, 4); pulse_stop("R11", 0);
    sub_en = 3'b000;
    addr_chk("R5 broadcast last", 8'hC0, 5); pulse_stop("R11", 0);
    all_addr = {SRST, 1'b0};
    addr_chk("R6 reserved beats broadcast", {SRST, 1'b0}, 6); pulse_stop("R11", 0);
    all_addr = 8'hD0;

    // reset call
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0); check("R9 key0 ack", int'(ack), 1);
    pulse_data(K1); check("R9 key1 ack", int'(ack), 1);
    pulse_stop("R9", 1);
    addr_chk("R6 reserved read", {SRST, 1'b1}, 0); pulse_stop("R6", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0); pulse_data(K1);
    pulse_data(K1); check("R10 third byte nack", int'(ack), 0);
    pulse_stop("R10", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K1); check("R10 wrong key0 nack", int'(ack), 0);
    pulse_data(K1); check("R10 after bad key nack", int'(ack), 0);
    pulse_stop("R10", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0); pulse_data(8'h00); check("R10 wrong key1 nack", int'(ack), 0);
    pulse_stop("R10", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0); pulse_stop("R10 one key only", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0);
    addr_chk("R12 restart device", {3'b110, pins, 1'b0}, 1);
    pulse_data(K1); check("R12 data acked as device", int'(ack), 1);
    pulse_stop("R12", 0);
    addr_chk("R6 reserved write", {SRST, 1'b0}, 6);
    pulse_data(K0);
    addr_chk("R12 restart reserved", {SRST, 1'b0}, 6);
    pulse_data(K1); check("R12 sequence restarted", int'(ack), 0);
    pulse_stop("R12", 0);

    // random transactions
    for (int t = 0; t < 300; t++) begin
      int sel;
      int ec;
      int nd;
      logic [7:0] a;
      pins = 4'($urandom);
      sub_en = 3'($urandom);
      sub_addr = {8'($urandom), 8'($urandom), 8'($urandom)};
      all_en = 1'($urandom);
      all_addr = 8'($urandom);
      sel = int'($urandom % 6);
      case (sel)
        0: a = {3'b110, pins, 1'b0};
        1, 2, 3: a = {sub_addr[(sel-1)*8+1 +: 7], 1'b0};
        4: a = {all_addr[7:1], 1'b0};
        default: a = {SRST, 1'b0};
      endcase
      if ($urandom % 5 == 0) a[7:1] = 7'($urandom);
      a[0] = 1'($urandom);
      ec = exp_class(a);
      addr_chk("R1 R2 R3 R4 R5 R6 random", a, ec);
      nd = (ec == 6) ? 0 : int'($urandom % 3);
      for (int d = 0; d < nd; d++) begin
        pulse_data(8'($urandom));
        check("R7 R8 random data ack", int'(ack), int'(ec != 0));
      end
      pulse_stop("R10 R11 random", 0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule